// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block holds the control and status byte of a successive-approximation converter and paces each conversion. A single register port sets the enable, start, auto-trigger, interrupt-enable and clock-divide fields. The same port reads back the running state and a completion flag. The system clock is divided down to an ADC clock, which appears as a one-cycle tick. Each conversion runs for a fixed number of those ticks.

Software starts a conversion by writing the start bit. When auto-triggering is on, a rising edge on the trigger input also starts one. The analog core is not part of the block. It sees a one-cycle pulse when sampling begins and a one-cycle pulse when the result is ready. The first conversion after the enable rises is longer, to cover initialization. Clearing the enable cancels a conversion that is in progress.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the register reads 0x00, and `irq_o`, `sample_o`, `eoc_o` and `adc_tick_o` are low.
- R2: The register layout is: bit 7 enable, bit 6 start/busy, bit 5 auto-trigger, bit 4 completion flag, bit 3 interrupt enable, bits 2:0 prescaler. Enable, auto-trigger, interrupt enable and prescaler read back as written. Bit 6 reads 1 exactly while a conversion runs.
- R3: Writing a value with bits 7 and 6 both set starts a conversion when none is running. Bit 6 reads 1 from the next cycle for the length of the conversion in system cycles.
- R4: The first conversion after the enable goes from 0 to 1 lasts 25 ADC clock cycles. Every later conversion lasts 13.
- R5: Prescaler codes 0 to 7 give ADC clock periods of 2, 2, 4, 8, 16, 32, 64 and 128 system cycles, so a conversion lasts length × period system cycles.
- R6: When a conversion completes, bit 4 is set. In the same cycle `eoc_o` pulses high for exactly one cycle.
- R7: Writing 1 to bit 4 clears the flag. Writing 0 to bit 4 leaves it unchanged.
- R8: `irq_o` is high exactly when both bit 4 and bit 3 are 1.
- R9: Writing 0 to bit 7 during a conversion stops it in that cycle. Bit 6 reads 0 on the next cycle, the flag is not set and `eoc_o` stays low.
- R10: With bits 7 and 5 set, a 0-to-1 change of `trig_i` starts a conversion. A trigger held high does not start another. No trigger edge starts one while bit 5 is 0.
- R11: A trigger edge that arrives during a running conversion is ignored. The conversion length is unchanged and no conversion follows it.
- R12: Each new 0-to-1 change of the enable brings back the 25-cycle first conversion, including after an abort.
- R13: `sample_o` pulses high for one cycle, in the first cycle of each conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write value |
| rd_data_o | output | 8 | Register read value |
| trig_i | input | 1 | External trigger, synchronous to clk_i |
| adc_tick_o | output | 1 | One-cycle pulse per ADC clock period while converting |
| sample_o | output | 1 | Sample pulse at conversion start |
| eoc_o | output | 1 | Result-ready pulse at conversion end |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `trig_i` is already synchronous to `clk_i`. They also assume the prescaler field is not rewritten while a conversion runs, so the tick spacing within one conversion is fixed. The stimulus changes the prescaler only with the converter idle. It drives the trigger and the write port at falling edges. The sweep covers every prescaler code, with first and later conversions, plus abort and trigger sequences at the smallest divide.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned PS_W      = 3;
  localparam int unsigned DIV_W     = 7;
  localparam int unsigned FIRST_LEN = 25;
  localparam int unsigned NORM_LEN  = 13;

  localparam int unsigned EN_BIT    = 7;
  localparam int unsigned START_BIT = 6;
  localparam int unsigned AUTO_BIT  = 5;
  localparam int unsigned FLAG_BIT  = 4;
  localparam int unsigned IE_BIT    = 3;

  typedef struct packed {
    logic            en;
    logic            auto_trig;
    logic            ie;
    logic [PS_W-1:0] ps;
  } ctrl_t;

  // terminal count of the divider: 2^max(ps,1) - 1
  function automatic logic [DIV_W-1:0] div_last(input logic [PS_W-1:0] ps);
    logic [DIV_W:0] one;
    int unsigned    sh;
    one = '0;
    one[0] = 1'b1;
    sh = (ps == '0) ? 1 : int'(ps);
    return DIV_W'((one << sh) - 1'b1);
  endfunction
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             done_i,
  input  logic             busy_i,
  output ctrl_t            ctrl_o,
  output logic             flag_o,
  output logic             en_nxt_o,
  output logic             en_rise_o,
  output logic             sw_start_o,
  output logic [REG_W-1:0] rd_data_o
);
  ctrl_t ctrl_q;
  logic  flag_q;

  always_comb begin
    en_nxt_o   = wr_en_i ? wr_data_i[EN_BIT] : ctrl_q.en;
    en_rise_o  = en_nxt_o & ~ctrl_q.en;
    sw_start_o = wr_en_i & wr_data_i[START_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      ctrl_q.en        <= wr_data_i[EN_BIT];
      ctrl_q.auto_trig <= wr_data_i[AUTO_BIT];
      ctrl_q.ie        <= wr_data_i[IE_BIT];
      ctrl_q.ps        <= wr_data_i[PS_W-1:0];
    end
  end

  // hardware set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                flag_q <= 1'b0;
    else if (done_i)                            flag_q <= 1'b1;
    else if (wr_en_i && wr_data_i[FLAG_BIT])    flag_q <= 1'b0;
  end

  always_comb begin
    rd_data_o            = '0;
    rd_data_o[EN_BIT]    = ctrl_q.en;
    rd_data_o[START_BIT] = busy_i;
    rd_data_o[AUTO_BIT]  = ctrl_q.auto_trig;
    rd_data_o[FLAG_BIT]  = flag_q;
    rd_data_o[IE_BIT]    = ctrl_q.ie;
    rd_data_o[PS_W-1:0]  = ctrl_q.ps;
  end

  assign ctrl_o = ctrl_q;
  assign flag_o = flag_q;

  a_r7_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !done_i && !(wr_en_i && wr_data_i[FLAG_BIT])) |=> flag_q);
endmodule

// File: rtl/adc_seq_presc.sv
module adc_seq_presc
  import adc_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last   = div_last(ps_i);
  assign tick_o = run_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  a_r5_tick_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> run_i);
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $stable(ps_i) |-> cnt_q <= last);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm #(
  parameter int unsigned FIRST_LEN = adc_seq_pkg::FIRST_LEN,
  parameter int unsigned NORM_LEN  = adc_seq_pkg::NORM_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_nxt_i,
  input  logic en_rise_i,
  input  logic sw_start_i,
  input  logic auto_i,
  input  logic trig_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o,
  output logic sample_o,
  output logic eoc_o
);
  localparam int unsigned MAX_LEN = (FIRST_LEN > NORM_LEN) ? FIRST_LEN : NORM_LEN;
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

  logic             busy_q, first_q, trig_q, sample_q, eoc_q;
  logic [LEN_W-1:0] cyc_q, len_q;
  logic             trig_rise, start_req, abort, use_first;

  assign trig_rise = trig_i & ~trig_q;
  assign start_req = ~busy_q & en_nxt_i & (sw_start_i | (auto_i & trig_rise));
  assign abort     = busy_q & ~en_nxt_i;
  assign use_first = first_q | en_rise_i;
  assign done_o    = busy_q & en_nxt_i & tick_i & (cyc_q == len_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        first_q <= 1'b0;
    else if (en_rise_i) first_q <= 1'b1;
    else if (done_o)    first_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cyc_q  <= '0;
      len_q  <= LEN_W'(NORM_LEN);
    end else if (start_req) begin
      busy_q <= 1'b1;
      cyc_q  <= '0;
      len_q  <= use_first ? LEN_W'(FIRST_LEN) : LEN_W'(NORM_LEN);
    end else if (abort || done_o) begin
      busy_q <= 1'b0;
      cyc_q  <= '0;
    end else if (busy_q && tick_i) begin
      cyc_q  <= cyc_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= 1'b0;
      eoc_q    <= 1'b0;
    end else begin
      sample_q <= start_req;
      eoc_q    <= done_o;
    end
  end

  assign busy_o   = busy_q;
  assign sample_o = sample_q;
  assign eoc_o    = eoc_q;

  a_r6_eoc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_q |=> !eoc_q);
  a_r9_abort_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> !busy_q && !eoc_q);
  a_r4_cyc_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cyc_q < len_q);
  a_r11_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_o && !abort |=> $stable(len_q));
  a_r13_sample_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_q |-> busy_q && cyc_q == '0);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int unsigned FIRST_CYC = adc_seq_pkg::FIRST_LEN,
  parameter int unsigned NORM_CYC  = adc_seq_pkg::NORM_LEN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             trig_i,
  output logic             adc_tick_o,
  output logic             sample_o,
  output logic             eoc_o,
  output logic             irq_o
);
  ctrl_t ctrl;
  logic  flag, en_nxt, en_rise, sw_start, busy, done, tick;

  adc_seq_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .done_i     (done),
    .busy_i     (busy),
    .ctrl_o     (ctrl),
    .flag_o     (flag),
    .en_nxt_o   (en_nxt),
    .en_rise_o  (en_rise),
    .sw_start_o (sw_start),
    .rd_data_o  (rd_data_o)
  );

  adc_seq_presc u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .ps_i   (ctrl.ps),
    .tick_o (tick)
  );

  adc_seq_fsm #(
    .FIRST_LEN (FIRST_CYC),
    .NORM_LEN  (NORM_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_nxt_i   (en_nxt),
    .en_rise_i  (en_rise),
    .sw_start_i (sw_start),
    .auto_i     (ctrl.auto_trig),
    .trig_i     (trig_i),
    .tick_i     (tick),
    .busy_o     (busy),
    .done_o     (done),
    .sample_o   (sample_o),
    .eoc_o      (eoc_o)
  );

  assign adc_tick_o = tick;
  assign irq_o      = flag & ctrl.ie;

  a_r2_busy_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> ctrl.en);
  a_r6_flag_with_eoc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> rd_data_o[FLAG_BIT]);
  a_r8_irq_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rd_data_o[IE_BIT] && rd_data_o[FLAG_BIT]);
endmodule

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       trig = 1'b0;
  logic       tick, sample, eoc, irq;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_top u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .trig_i     (trig),
    .adc_tick_o (tick),
    .sample_o   (sample),
    .eoc_o      (eoc),
    .irq_o      (irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // counts cycles with bit 6 high, starting at the current falling edge
  task automatic measure(output int n, output bit saw_eoc);
    n = 0;
    while (rd_data[6] && n < 20000) begin
      n++;
      @(negedge clk);
    end
    saw_eoc = eoc;
  endtask

  function automatic int period(input int ps);
    return 1 << ((ps == 0) ? 1 : ps);
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int  n;
    bit  e;
    repeat (3) @(negedge clk);
    chk(rd_data == 8'h00, "R1 reg", rd_data, 0);
    chk({irq, sample, eoc, tick} == 4'b0, "R1 outs", {irq, sample, eoc, tick}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 readback without start
    wr(8'hAD);
    chk(rd_data == 8'hAD, "R2 readback", rd_data, 8'hAD);
    wr(8'h00);
    chk(rd_data == 8'h00, "R2 clear", rd_data, 0);

    // R3 R4 R5 R6 R7 R8 R13 over every prescaler code
    for (int ps = 0; ps < 8; ps++) begin
      wr(8'hC0 | 8'(ps));
      chk(sample == 1'b1, "R13 sample first", sample, 1);
      chk(rd_data[6] == 1'b1, "R3 busy", rd_data[6], 1);
      @(negedge clk);
      chk(sample == 1'b0, "R13 sample single", sample, 0);
      measure(n, e);
      n++;
      chk(n == 25 * period(ps), "R4 R5 first length", n, 25 * period(ps));
      chk(e && rd_data[4], "R6 eoc and flag", {e, rd_data[4]}, 3);
      chk(irq == 1'b0, "R8 irq needs ie", irq, 0);
      @(negedge clk);
      chk(eoc == 1'b0, "R6 eoc single", eoc, 0);
      wr(8'hD8 | 8'(ps));
      measure(n, e);
      chk(n == 13 * period(ps), "R4 R5 later length", n, 13 * period(ps));
      chk(rd_data[4] && irq, "R8 irq set", {rd_data[4], irq}, 3);
      wr(8'h88 | 8'(ps));
      chk(rd_data[4] == 1'b1, "R7 write 0 keeps", rd_data[4], 1);
      wr(8'h98 | 8'(ps));
      chk(rd_data[4] == 1'b0 && irq == 1'b0, "R7 R8 clear", {rd_data[4], irq}, 0);
      wr(8'h00);
    end

    // R9 abort, R12 re-arm
    wr(8'hC1);
    repeat (19) @(negedge clk);
    wr(8'h01);
    chk(rd_data[6] == 1'b0, "R9 stopped", rd_data[6], 0);
    chk(rd_data[4] == 1'b0 && eoc == 1'b0, "R9 no flag", {rd_data[4], eoc}, 0);
    repeat (60) @(negedge clk);
    chk(rd_data[6] == 1'b0 && rd_data[4] == 1'b0, "R9 stays idle", rd_data, 1);
    wr(8'hC1);
    measure(n, e);
    chk(n == 50, "R12 first again", n, 50);
    wr(8'hD1);
    measure(n, e);
    chk(n == 26, "R12 later", n, 26);
    wr(8'h91);

    // R10 auto trigger
    wr(8'hA1);
    chk(rd_data[6] == 1'b0, "R10 no start on write", rd_data[6], 0);
    trig = 1'b1;
    @(negedge clk);
    chk(rd_data[6] == 1'b1, "R10 edge starts", rd_data[6], 1);
    measure(n, e);
    chk(n == 26, "R10 length", n, 26);
    repeat (20) @(negedge clk);
    chk(rd_data[6] == 1'b0, "R10 level no restart", rd_data[6], 0);
    trig = 1'b0;
    @(negedge clk);

    // R11 edge during conversion ignored
    trig = 1'b1;
    @(negedge clk);
    n = 0;
    while (rd_data[6] && n < 1000) begin
      n++;
      if (n == 5) trig = 1'b0;
      if (n == 8) trig = 1'b1;
      @(negedge clk);
    end
    chk(n == 26, "R11 length unchanged", n, 26);
    repeat (20) @(negedge clk);
    chk(rd_data[6] == 1'b0, "R11 no follow-on", rd_data[6], 0);
    trig = 1'b0;

    // R10 auto off
    wr(8'h91);
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    chk(rd_data[6] == 1'b0, "R10 auto off", rd_data[6], 0);
    trig = 1'b0;
    repeat (5) @(negedge clk);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule